// File: doc/BRIEF.md
# Banked ROM Cartridge Mapper with Guarded RAM

This block sits between an 8-bit console address bus and the memory on a plug-in cartridge. It places one of three 4 KB ROM banks in a 4 KB address window. It also provides 256 bytes of on-cartridge RAM. The RAM is reached through two separate address ranges: one for writes and one for reads. The console has no separate write strobe into the cartridge area, so a program that reads the write range by mistake overwrites the addressed RAM cell with whatever value was floating on the data bus. The block models that side effect faithfully.

The block also records the cartridge-space address of the most recent such read in a debug status register. A debugger can poll this register. A zero value means nothing has happened since the last poll, and a poll that finds a nonzero value clears the register. A lock input lets a debugger inspect the cartridge without disturbing it. While lock is high, reads cause no RAM write, no error record and no bank change.

The ROM itself is external. The block drives a ROM byte address made of the bank number and the local offset, and it registers the returned byte.

Top module: `cart_mapper`

## Requirements
- R1: Only the low 12 bits of `addr` take part in decoding; any value in `addr[15:12]` gives the same behaviour as zero.
- R2: A read at local offset 0x200..0xFFF returns, one cycle after `rd_en`, the external ROM byte at `rom_addr = {bank[1:0], offset[11:0]}`, with `rd_valid` high in that cycle. `rom_addr` follows `addr` combinationally. `rd_valid` is low in a cycle after a clock with `rd_en` low.
- R3: A read or a write at offset 0xFF8, 0xFF9 or 0xFFA selects bank 0, 1 or 2 respectively, starting with the next access. A read of the hotspot itself returns the byte from the previously selected bank. Reset selects bank 0.
- R4: A write at offset 0x000..0x0FF stores `wr_data` in RAM cell `offset[7:0]`. A read at offset 0x100..0x1FF returns RAM cell `offset[7:0]`.
- R5: Writes at offsets 0x100..0xFFF that are not hotspots leave every RAM cell unchanged.
- R6: An unlocked read at offset 0x000..0x0FF returns `bus_last` and also stores `bus_last` in RAM cell `offset[7:0]`.
- R7: Each unlocked read at offset 0x000..0x0FF loads the 13-bit status register with `{1'b1, offset[11:0]}` (0x1000 + offset). A later such read replaces an earlier one.
- R8: A clock with `stat_rd` high makes `stat_data` show the register value from before that edge, from the next cycle until the next `stat_rd`. The register then becomes zero, unless a new illegal read lands in the same cycle, in which case it holds that new record. Zero means no illegal read since the last poll.
- R9: While `lock` is high, a read at offset 0x000..0x0FF still returns `bus_last` but writes no RAM cell and leaves the status register unchanged. Hotspot accesses do not change the bank. Ordinary writes to 0x000..0x0FF are still stored.
- R10: When `rd_en` and `wr_en` are high together, only the read takes place; the write data is discarded.
- R11: Reset does not clear the RAM; cell contents written before reset read back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address; low 12 bits are the local offset |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 8 | Write data |
| bus_last | input | 8 | Floating data-bus value seen on a read |
| lock | input | 1 | Debugger lock; suppresses read side effects and bank changes |
| rom_addr | output | 14 | External ROM byte address {bank, offset} |
| rom_data | input | 8 | Byte returned by the external ROM for rom_addr |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| stat_rd | input | 1 | Poll the debug status register |
| stat_data | output | 13 | Value returned by the last poll |

## Verification
The bench targets the read of the write range under both lock states. A design that ignored lock would corrupt RAM and raise a false record during debugger inspection. A design that dropped the side effect would leave stale RAM that the read port then exposes. It polls the status register twice in a row and also in the same cycle as a fresh illegal read. A wrong clear would return stale addresses or lose the new one. It also steps the hotspots by read and by write, with and without lock, and checks that a hotspot read still returns the old bank's byte. Off-by-one bank timing shows up there as wrong ROM addresses. Simultaneous read and write strobes, upper address bits and a mid-run reset probe that writes are discarded, that the address is masked, and that RAM survives reset.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [1:0] {
    RGN_WPORT = 2'd0,
    RGN_RPORT = 2'd1,
    RGN_ROM   = 2'd2
  } region_e;
endpackage

// File: rtl/cm_decode.sv
module cm_decode
  import cm_pkg::*;
#(
  parameter int unsigned LOCAL_W    = 12,
  parameter int unsigned RAM_AW     = 8,
  parameter int unsigned BANKS      = 3,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned HOT_BASE   = 'hFF8,
  parameter int unsigned WPORT_BASE = 'h000,
  parameter int unsigned RPORT_BASE = 'h100
) (
  input  logic [LOCAL_W-1:0] off,
  output region_e            rgn,
  output logic               hot,
  output logic [BANK_W-1:0]  hot_idx
);
  logic [BANKS-1:0] hit_vec;

  for (genvar g = 0; g < BANKS; g++) begin : g_hot
    assign hit_vec[g] = (off == LOCAL_W'(HOT_BASE + g));
  end

  always_comb begin
    hot     = |hit_vec;
    hot_idx = '0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hot_idx = BANK_W'(i);
    end
  end

  always_comb begin
    if (off[LOCAL_W-1:RAM_AW] == (LOCAL_W-RAM_AW)'(WPORT_BASE >> RAM_AW))
      rgn = RGN_WPORT;
    else if (off[LOCAL_W-1:RAM_AW] == (LOCAL_W-RAM_AW)'(RPORT_BASE >> RAM_AW))
      rgn = RGN_RPORT;
    else
      rgn = RGN_ROM;
  end
endmodule

// File: rtl/cm_bank.sv
module cm_bank #(
  parameter int unsigned BANKS      = 3,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned RESET_BANK = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [BANK_W-1:0] idx,
  input  logic              lock,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst)
      bank <= BANK_W'(RESET_BANK);
    else if (hit && !lock)
      bank <= idx;
  end

  p_bank_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    bank < BANK_W'(BANKS));

  p_hotspot_selects_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && !lock) |=> bank == $past(idx));

  p_lock_freezes_bank_r9: assert property (@(posedge clk) disable iff (rst)
    lock |=> bank == $past(bank));
endmodule

// File: rtl/cm_ram.sv
module cm_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/cm_trap.sv
module cm_trap #(
  parameter int unsigned LOCAL_W = 12,
  parameter int unsigned STAT_W  = LOCAL_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rec,
  input  logic [LOCAL_W-1:0] rec_off,
  input  logic               query,
  output logic [STAT_W-1:0]  stat_q
);
  logic [STAT_W-1:0] status;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      stat_q <= '0;
    end else begin
      if (query) begin
        stat_q <= status;
        if (status != '0) status <= '0;
      end
      if (rec) status <= {1'b1, rec_off};
    end
  end

  p_record_latches_r7: assert property (@(posedge clk) disable iff (rst)
    rec |=> status == {1'b1, $past(rec_off)});

  p_status_tagged_r7: assert property (@(posedge clk) disable iff (rst)
    (status != '0) |-> status[STAT_W-1]);

  p_poll_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (query && !rec) |=> status == '0);

  p_poll_returns_r8: assert property (@(posedge clk) disable iff (rst)
    query |=> stat_q == $past(status));
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cm_pkg::*;
#(
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned LOCAL_W    = 12,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANKS      = 3,
  parameter int unsigned RAM_BYTES  = 256,
  parameter int unsigned HOT_BASE   = 'hFF8,
  parameter int unsigned WPORT_BASE = 'h000,
  parameter int unsigned RPORT_BASE = 'h100,
  parameter int unsigned RESET_BANK = 0,
  localparam int unsigned RAM_AW    = $clog2(RAM_BYTES),
  localparam int unsigned BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int unsigned ROM_AW    = BANK_W + LOCAL_W,
  localparam int unsigned STAT_W    = LOCAL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] bus_last,
  input  logic              lock,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_data
);
  logic [LOCAL_W-1:0] off;
  logic               unused_hi;
  region_e            rgn;
  logic               hot;
  logic [BANK_W-1:0]  hot_idx;
  logic [BANK_W-1:0]  bank;
  logic               wr_act;
  logic               trap_rd;
  logic               ram_we;
  logic [DATA_W-1:0]  ram_wd;
  logic [DATA_W-1:0]  ram_q;

  region_e            sel_q;
  logic               valid_q;
  logic [DATA_W-1:0]  rom_q;
  logic [DATA_W-1:0]  bus_q;

  assign off       = addr[LOCAL_W-1:0];
  assign unused_hi = ^addr[BUS_W-1:LOCAL_W];

  cm_decode #(
    .LOCAL_W(LOCAL_W), .RAM_AW(RAM_AW), .BANKS(BANKS), .BANK_W(BANK_W),
    .HOT_BASE(HOT_BASE), .WPORT_BASE(WPORT_BASE), .RPORT_BASE(RPORT_BASE)
  ) u_decode (
    .off(off), .rgn(rgn), .hot(hot), .hot_idx(hot_idx)
  );

  // Read strobe wins over a simultaneous write strobe.
  assign wr_act  = wr_en && !rd_en;
  assign trap_rd = rd_en && (rgn == RGN_WPORT) && !lock;
  assign ram_we  = !rst && ((wr_act && (rgn == RGN_WPORT)) || trap_rd);
  assign ram_wd  = trap_rd ? bus_last : wr_data;

  cm_bank #(
    .BANKS(BANKS), .BANK_W(BANK_W), .RESET_BANK(RESET_BANK)
  ) u_bank (
    .clk(clk), .rst(rst), .hit((rd_en || wr_en) && hot),
    .idx(hot_idx), .lock(lock), .bank(bank)
  );

  cm_ram #(
    .DATA_W(DATA_W), .AW(RAM_AW)
  ) u_ram (
    .clk(clk), .we(ram_we), .waddr(off[RAM_AW-1:0]), .wdata(ram_wd),
    .raddr(off[RAM_AW-1:0]), .q(ram_q)
  );

  cm_trap #(
    .LOCAL_W(LOCAL_W), .STAT_W(STAT_W)
  ) u_trap (
    .clk(clk), .rst(rst), .rec(trap_rd), .rec_off(off),
    .query(stat_rd), .stat_q(stat_data)
  );

  assign rom_addr = {bank, off};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sel_q   <= RGN_ROM;
    end else begin
      valid_q <= rd_en;
      if (rd_en) sel_q <= rgn;
    end
    rom_q <= rom_data;
    bus_q <= bus_last;
  end

  always_comb begin
    unique case (sel_q)
      RGN_WPORT: rd_data = bus_q;
      RGN_RPORT: rd_data = ram_q;
      default:   rd_data = rom_q;
    endcase
  end

  assign rd_valid = valid_q;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_idle_not_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_wport_returns_bus_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rgn == RGN_WPORT) |=> rd_data == $past(bus_last));

  p_hot_in_rom_r3: assert property (@(posedge clk) disable iff (rst)
    hot |-> rgn == RGN_ROM);
endmodule

// File: tb/test_cart_mapper.sv
module test_cart_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, lock = 1'b0, stat_rd = 1'b0;
  logic [7:0]  wr_data = '0, bus_last = '0;
  logic [13:0] rom_addr;
  logic [7:0]  rom_data, rd_data;
  logic        rd_valid;
  logic [12:0] stat_data;

  always #5 clk = ~clk;

  cart_mapper i_cart_mapper (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .bus_last(bus_last), .lock(lock),
    .rom_addr(rom_addr), .rom_data(rom_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .stat_rd(stat_rd), .stat_data(stat_data)
  );

  function automatic logic [7:0] rom_fn(input logic [13:0] a);
    return a[7:0] ^ a[11:4] ^ (8'(a[13:12]) * 8'h5B);
  endfunction

  always_comb rom_data = rom_fn(rom_addr);

  int errors = 0, checks = 0;
  logic [7:0]  ram_m [256];
  int          bank_m = 0;
  logic [12:0] st_m = '0, stq_m = '0;
  logic [7:0]  lf = 8'hA5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [15:0] a,
                      input logic [7:0] d, input logic [7:0] bl, input bit lk,
                      input bit srd, input string tag);
    logic [11:0] o;
    logic [7:0]  ed;
    logic [12:0] ra;
    logic [13:0] era;
    bit          rec;
    @(negedge clk);
    addr = a; rd_en = rd; wr_en = wr; wr_data = d; bus_last = bl;
    lock = lk; stat_rd = srd;
    #1;
    o   = a[11:0];
    era = {bank_m[1:0], o};
    chk(rom_addr == era, {tag, " R2 rom_addr"}, rom_addr, era);
    ed = '0; rec = 0; ra = '0;
    if (rd) begin
      if (o < 12'h100) begin
        ed = bl;
        if (!lk) begin ram_m[o[7:0]] = bl; rec = 1; ra = {1'b1, o}; end
      end else if (o < 12'h200) ed = ram_m[o[7:0]];
      else ed = rom_fn(era);
    end else if (wr && o < 12'h100) ram_m[o[7:0]] = d;
    if ((rd || wr) && !lk && o >= 12'hFF8 && o <= 12'hFFA) bank_m = int'(o) - 'hFF8;
    if (srd) begin stq_m = st_m; st_m = '0; end
    if (rec) st_m = ra;
    @(posedge clk); #1;
    chk(rd_valid == rd, {tag, " R2 rd_valid"}, rd_valid, rd);
    if (rd) chk(rd_data == ed, {tag, " rd_data"}, rd_data, ed);
    chk(stat_data == stq_m, {tag, " R8 stat_data"}, stat_data, stq_m);
  endtask

  task automatic rd_(input logic [15:0] a, input logic [7:0] bl, input bit lk, input string tag);
    step(1, 0, a, 8'h00, bl, lk, 0, tag);
  endtask

  task automatic wr_(input logic [15:0] a, input logic [7:0] d, input bit lk, input string tag);
    step(0, 1, a, d, 8'h00, lk, 0, tag);
  endtask

  task automatic poll(input string tag);
    step(0, 0, 16'h0200, 8'h00, 8'h00, 0, 1, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rd_en = 0; wr_en = 0; stat_rd = 0; lock = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    bank_m = 0; st_m = '0; stq_m = '0;
    #1;
    chk(rd_valid == 1'b0, "R2 reset rd_valid", rd_valid, 0);
    chk(stat_data == '0, "R8 reset stat_data", stat_data, 0);
    chk(rom_addr[13:12] == 2'd0, "R3 reset bank", rom_addr[13:12], 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R4: power-up contents modelled by an LFSR, loaded through the write range
    for (int i = 0; i < 256; i++) begin
      wr_(16'(i), lf, 0, "R4 fill");
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    for (int i = 0; i < 256; i++) rd_(16'h0100 + 16'(i), 8'h00, 0, "R4 readback");

    // R1: upper address bits ignored
    rd_(16'hF105, 8'h00, 0, "R1 upper bits read");
    wr_(16'h7003, 8'hC3, 0, "R1 upper bits write");
    rd_(16'h0103, 8'h00, 0, "R1 masked write landed");

    // R2/R3: ROM banks via hotspots
    rd_(16'h0200, 8'h00, 0, "R2 bank0 low");
    rd_(16'h0FFF, 8'h00, 0, "R2 bank0 top");
    rd_(16'h0FF9, 8'h00, 0, "R3 hotspot read old bank");
    rd_(16'h0400, 8'h00, 0, "R3 bank1 after read hotspot");
    wr_(16'h0FFA, 8'h00, 0, "R3 write hotspot");
    rd_(16'h0400, 8'h00, 0, "R3 bank2 after write hotspot");
    rd_(16'h3FF8, 8'h00, 0, "R3 hotspot masked");
    rd_(16'h0800, 8'h00, 0, "R3 bank0 again");

    // R5: writes outside the write range ignored
    wr_(16'h01A0, 8'h11, 0, "R5 write to read range");
    rd_(16'h01A0, 8'h00, 0, "R5 read range unchanged");
    wr_(16'h05A0, 8'h22, 0, "R5 write to rom area");
    rd_(16'h01A0, 8'h00, 0, "R5 cell unchanged after rom write");

    // R6/R7/R8: illegal read, record, poll and clear
    rd_(16'h0022, 8'h3C, 0, "R6 illegal read returns bus");
    rd_(16'h0122, 8'h00, 0, "R6 bus value stored");
    poll("R7 record address");
    poll("R8 cleared after poll");
    rd_(16'h0010, 8'h41, 0, "R6 first illegal");
    rd_(16'h00F0, 8'h42, 0, "R6 second illegal");
    poll("R7 latest record wins");
    step(1, 0, 16'h0033, 8'h00, 8'h77, 0, 1, "R8 poll with same-cycle record");
    poll("R8 same-cycle record kept");
    poll("R8 zero means none");

    // R9: lock suppresses side effects
    rd_(16'h0044, 8'h99, 1, "R9 locked illegal read");
    rd_(16'h0144, 8'h00, 0, "R9 no RAM write under lock");
    poll("R9 no record under lock");
    rd_(16'h0FF9, 8'h00, 1, "R9 locked read hotspot");
    wr_(16'h0FFA, 8'h00, 1, "R9 locked write hotspot");
    rd_(16'h0300, 8'h00, 0, "R9 bank unchanged");
    wr_(16'h0055, 8'h5E, 1, "R9 locked write");
    rd_(16'h0155, 8'h00, 0, "R9 locked write stored");

    // R10: simultaneous strobes, read wins
    step(1, 1, 16'h0160, 8'hEE, 8'h00, 0, 0, "R10 both strobes read");
    rd_(16'h0160, 8'h00, 0, "R10 write discarded");
    step(1, 1, 16'h0066, 8'hEE, 8'h12, 0, 0, "R10 both strobes on write range");
    rd_(16'h0166, 8'h00, 0, "R10 bus value kept not wr_data");
    poll("R10 record from read");

    // R11: reset keeps RAM, reselects bank 0
    wr_(16'h0FF9, 8'h00, 0, "R3 select bank1 before reset");
    do_reset();
    for (int i = 0; i < 16; i++) rd_(16'h0100 + 16'(i * 17), 8'h00, 0, "R11 RAM kept over reset");
    rd_(16'h0500, 8'h00, 0, "R11 bank0 after reset");

    // Mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int r;
      r = $urandom_range(0, 5);
      case (r)
        0:       a = 16'h0000 + 16'($urandom_range(0, 255));
        1, 2:    a = 16'h0100 + 16'($urandom_range(0, 255));
        3:       a = 16'h0FF8 + 16'($urandom_range(0, 3));
        default: a = 16'($urandom_range(512, 4095));
      endcase
      a[15:12] = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 1) == 1), ($urandom_range(0, 2) == 0), a,
           8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 5) == 0), "R9 R7 mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule